// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing backbone of a pulse-width modulator. A 16-bit counter advances once per prescaled tick and runs up, down, up-then-down, or holds still, as chosen by a control word. The counter limit comes from a period register. That register is double-buffered, so software can change the period without tearing the waveform in flight.

The block gives out the counter value and the current counting direction. It also gives two one-clock strobes: one when the counter lands on zero and one when it lands on the active period. Compare and output logic further down the chain uses these to build waveforms.

Two write ports, each a single-cycle write strobe with data, load the control word and the period.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset the count is 0, both strobes are low, the direction output is 0 (up), and the control state is all zero: up mode, shadow load, divide by 1.
- R2: Control bits 1:0 pick the mode: 00 up, 01 down, 10 up-down, 11 hold. Control bit 3 picks period loading: 0 shadow, 1 immediate. Bits 9:7 hold the low prescale field L and bits 12:10 hold the high field H. All other bits are ignored.
- R3: The counter advances once every R clocks, where R = (L==0 ? 1 : 2*L) * 2^H. This gives ratios from 1 up to 1792.
- R4: In up mode each tick adds 1 until the count reaches or exceeds the active period P; the next tick then returns it to 0. The direction output is 0.
- R5: In down mode a tick at count 0 loads P, and any other tick subtracts 1. The direction output is 1.
- R6: In up-down mode the count rises to P, then falls to 0, then rises again. The direction output becomes 1 on the tick that leaves P and becomes 0 on the tick that leaves 0.
- R7: In hold mode the count and the direction do not change and neither strobe fires.
- R8: The zero strobe and the period strobe are high for exactly the one clock that follows a counting tick which leaves the count at 0 or at the active period, respectively.
- R9: In shadow mode a period write goes only to the shadow copy. The shadow copy moves to the active period on a counting tick taken while the count is 0.
- R10: In immediate mode a period write sets both the active period and the shadow copy at once. A count above the new period returns to 0 on the next up-mode tick.
- R11: Any control write restarts the prescaler, so the next tick comes a full R clocks after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period value |
| cnt | output | 16 | Counter value |
| cnt_down | output | 1 | Direction, 1 while counting down |
| zero_evt | output | 1 | One-clock strobe, counter reached 0 |
| prd_evt | output | 1 | One-clock strobe, counter reached the active period |

## Verification
The bench first tests a shadow write made mid-period. A design that applied the shadow too early would wrap at the new value before reaching the old period. It then shrinks the period by immediate write below the running count; a design using an equality compare would run on to 65535 instead of wrapping. It also rewrites the control word part-way through a prescale interval; a design that did not restart the prescaler would tick early. Finally it checks the reversal points of up-down mode, where an off-by-one in the direction flag would either repeat the peak or skip it, and the largest ratio of 1792, where a short ratio register would wrap.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_HOLD   = 2'b11
  } cnt_mode_e;

  // control word field positions (decoded by software drivers)
  localparam int MODE_LSB = 0;
  localparam int IMM_BIT  = 3;
  localparam int LO_LSB   = 7;
  localparam int LO_W     = 3;
  localparam int HI_LSB   = LO_LSB + LO_W;
  localparam int HI_W     = 3;
endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler #(
  parameter int LO_W = 3,
  parameter int HI_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [LO_W-1:0] lo_div,
  input  logic [HI_W-1:0] hi_div,
  output logic            tick
);
  localparam int RATIO_W = LO_W + 1 + (1 << HI_W) - 1;

  logic [RATIO_W-1:0] base;
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] psc_q;

  always_comb begin
    if (lo_div == '0) base = RATIO_W'(1);
    else              base = RATIO_W'({lo_div, 1'b0});
    ratio = base << hi_div;
  end

  assign tick = (psc_q == ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) psc_q <= '0;
    else if (tick)      psc_q <= '0;
    else                psc_q <= psc_q + RATIO_W'(1);
  end
endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             imm_mode,
  input  logic             load_evt,
  output logic [CNT_W-1:0] prd_q,
  output logic [CNT_W-1:0] prd_next
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] shadow_next;

  always_comb begin
    prd_next    = prd_q;
    shadow_next = shadow_q;
    if (wr_en) shadow_next = wr_data;
    if (wr_en && imm_mode)      prd_next = wr_data;
    else if (load_evt && !imm_mode) prd_next = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q    <= '0;
      shadow_q <= '0;
    end else begin
      prd_q    <= prd_next;
      shadow_q <= shadow_next;
    end
  end
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] prd_next,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             zero_q,
  output logic             peak_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             dir_d;
  logic             adv;

  assign adv = tick && (mode != CM_HOLD);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (adv) begin
      unique case (mode)
        CM_UP: begin
          dir_d = 1'b0;
          cnt_d = (cnt_q >= prd) ? '0 : cnt_q + ONE;
        end
        CM_DOWN: begin
          dir_d = 1'b1;
          cnt_d = (cnt_q == '0) ? prd : cnt_q - ONE;
        end
        CM_UPDOWN: begin
          if (!dir_q) begin
            if (cnt_q >= prd) begin
              dir_d = 1'b1;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d = 1'b0;
              cnt_d = (prd == '0) ? '0 : ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      zero_q <= 1'b0;
      peak_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      zero_q <= adv && (cnt_d == '0);
      peak_q <= adv && (cnt_d == prd_next);
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTRL_W-1:0] ctl_wdata,
  input  logic              prd_we,
  input  logic [CNT_W-1:0]  prd_wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_down,
  output logic              zero_evt,
  output logic              prd_evt
);
  cnt_mode_e        mode_q;
  logic             imm_q;
  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             tick_w;
  logic             ld_evt;
  logic [CNT_W-1:0] prd_act;
  logic [CNT_W-1:0] prd_nx;
  logic             unused_ctl;

  assign unused_ctl = ^ctl_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CM_UP;
      imm_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (ctl_we) begin
      mode_q <= cnt_mode_e'(ctl_wdata[MODE_LSB +: 2]);
      imm_q  <= ctl_wdata[IMM_BIT];
      lo_q   <= ctl_wdata[LO_LSB +: LO_W];
      hi_q   <= ctl_wdata[HI_LSB +: HI_W];
    end
  end

  pwmtb_prescaler #(.LO_W(LO_W), .HI_W(HI_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .restart (ctl_we),
    .lo_div  (lo_q),
    .hi_div  (hi_q),
    .tick    (tick_w)
  );

  assign ld_evt = tick_w && (mode_q != CM_HOLD) && (cnt == '0);

  pwmtb_period #(.CNT_W(CNT_W)) u_prd (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (prd_we),
    .wr_data  (prd_wdata),
    .imm_mode (imm_q),
    .load_evt (ld_evt),
    .prd_q    (prd_act),
    .prd_next (prd_nx)
  );

  pwmtb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .mode     (mode_q),
    .prd      (prd_act),
    .prd_next (prd_nx),
    .cnt_q    (cnt),
    .dir_q    (cnt_down),
    .zero_q   (zero_evt),
    .peak_q   (prd_evt)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input cnt_mode_e        mode,
  input logic             imm,
  input logic             tick,
  input logic             ld,
  input logic             prd_we,
  input logic [CNT_W-1:0] prd,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_down,
  input logic             zero_evt,
  input logic             prd_evt
);
  a_r8_zero_at_zero: assert property (@(posedge clk) disable iff (rst)
    zero_evt |-> (cnt == '0));

  a_r8_peak_at_period: assert property (@(posedge clk) disable iff (rst)
    prd_evt |-> (cnt == prd));

  a_r7_hold_count: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_HOLD) |=> $stable(cnt));

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_HOLD) |=> (!zero_evt && !prd_evt));

  a_r3_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_UP && tick && cnt < prd) |=> (cnt == $past(cnt) + CNT_W'(1)));

  a_r4_up_dir: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_UP && tick) |=> !cnt_down);

  a_r5_down_dir: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_DOWN && tick) |=> cnt_down);

  a_r9_shadow_keeps: assert property (@(posedge clk) disable iff (rst)
    (!imm && !ld) |=> $stable(prd));

  a_r10_imm_write: assert property (@(posedge clk) disable iff (rst)
    (imm && !prd_we) |=> $stable(prd));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode_q),
  .imm      (imm_q),
  .tick     (tick_w),
  .ld       (ld_evt),
  .prd_we   (prd_we),
  .prd      (prd_act),
  .cnt      (cnt),
  .cnt_down (cnt_down),
  .zero_evt (zero_evt),
  .prd_evt  (prd_evt)
);

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        prd_we = 1'b0;
  logic [15:0] prd_wdata = '0;
  logic [15:0] cnt;
  logic        cnt_down, zero_evt, prd_evt;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_timebase uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prd_we(prd_we), .prd_wdata(prd_wdata), .cnt(cnt),
    .cnt_down(cnt_down), .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  // ctrl: bits1:0 mode, bit3 immediate, bits9:7 low field, bits12:10 high field
  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] prd;
    logic [15:0] n;
    logic [15:0] cnt;
    logic        dir;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{16'h0000, 16'd5, 16'd3,    16'd3, 1'b0}, // R4 up
    '{16'h0000, 16'd5, 16'd8,    16'd2, 1'b0}, // R4 wrap
    '{16'h0080, 16'd4, 16'd11,   16'd0, 1'b0}, // R3 /2
    '{16'h0180, 16'd9, 16'd40,   16'd6, 1'b0}, // R3 /6
    '{16'h0800, 16'd3, 16'd18,   16'd0, 1'b0}, // R3 /4 high field
    '{16'h0500, 16'd7, 16'd30,   16'd3, 1'b0}, // R3 /8 both fields
    '{16'h0001, 16'd5, 16'd1,    16'd5, 1'b1}, // R5 load at 0
    '{16'h0001, 16'd5, 16'd4,    16'd2, 1'b1}, // R5
    '{16'h0001, 16'd5, 16'd7,    16'd5, 1'b1}, // R5 reload
    '{16'h0002, 16'd4, 16'd3,    16'd3, 1'b0}, // R6
    '{16'h0002, 16'd4, 16'd4,    16'd4, 1'b0}, // R6 peak
    '{16'h0002, 16'd4, 16'd6,    16'd2, 1'b1}, // R6 falling
    '{16'h0002, 16'd4, 16'd8,    16'd0, 1'b1}, // R6 bottom
    '{16'h0002, 16'd4, 16'd9,    16'd1, 1'b0}, // R6 rising again
    '{16'h0003, 16'd4, 16'd10,   16'd0, 1'b0}, // R7 hold
    '{16'h1F80, 16'd3, 16'd3584, 16'd2, 1'b0}  // R3 max ratio 1792
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    steps(2);
    rst = 1'b0;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic wr_prd(input logic [15:0] v);
    prd_we = 1'b1; prd_wdata = v;
    step();
    prd_we = 1'b0;
  endtask

  // hold + immediate, load period, then the mode under test
  task automatic setup(input logic [15:0] ctrl, input logic [15:0] p);
    do_reset();
    wr_ctl(16'h000B);
    wr_prd(p);
    wr_ctl(ctrl);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #2;
    // R1 reset state
    do_reset();
    chk("R1 cnt", cnt, 0);
    chk("R1 dir", cnt_down, 0);
    chk("R1 zero", zero_evt, 0);
    chk("R1 peak", prd_evt, 0);

    // table walk (R2 mode decode throughout)
    foreach (VECS[k]) begin
      setup(VECS[k].ctrl, VECS[k].prd);
      steps(int'(VECS[k].n));
      chk($sformatf("R2 vec%0d cnt", k), cnt, int'(VECS[k].cnt));
      chk($sformatf("R2 vec%0d dir", k), cnt_down, int'(VECS[k].dir));
    end

    // R8 strobes single clock, up /3 period 2
    setup(16'h0100 | 16'h0000, 16'd2); // low field 2 -> /4; use /3? no: recompute
    // ratio 4: ticks at steps 4,8,12
    steps(8);
    chk("R8 cnt at peak", cnt, 2);
    chk("R8 peak strobe", prd_evt, 1);
    chk("R8 zero quiet", zero_evt, 0);
    step();
    chk("R8 peak one clock", prd_evt, 0);
    steps(3);
    chk("R8 cnt wrap", cnt, 0);
    chk("R8 zero strobe", zero_evt, 1);
    step();
    chk("R8 zero one clock", zero_evt, 0);

    // R8 down mode strobes
    setup(16'h0001, 16'd3);
    step();
    chk("R8 down peak", prd_evt, 1);
    steps(3);
    chk("R8 down zero", zero_evt, 1);
    chk("R5 down cnt", cnt, 0);

    // R9 shadow load waits for zero
    setup(16'h0000, 16'd4);
    step();
    wr_prd(16'd2);
    chk("R9 cnt", cnt, 2);
    steps(2);
    chk("R9 old period kept", cnt, 4);
    step();
    chk("R9 wrap at old", cnt, 0);
    steps(2);
    chk("R9 new period", cnt, 2);
    step();
    chk("R9 wrap at new", cnt, 0);

    // R10 immediate shrink below count
    setup(16'h0008, 16'd9);
    steps(5);
    wr_prd(16'd3);
    chk("R10 cnt", cnt, 6);
    step();
    chk("R10 wrap above period", cnt, 0);

    // R11 control rewrite restarts prescaler (ratio 4)
    setup(16'h0800, 16'd9);
    steps(2);
    wr_ctl(16'h0800);
    steps(3);
    chk("R11 no early tick", cnt, 0);
    step();
    chk("R11 tick after full ratio", cnt, 1);

    // R7 hold freezes mid-run, no strobes
    setup(16'h0000, 16'd3);
    steps(2);
    wr_ctl(16'h0003);
    chk("R7 last count", cnt, 3);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R7 held cnt", cnt, 3);
      chk("R7 no strobe", int'(zero_evt | prd_evt), 0);
    end

    // R2 ignored bits: junk in bits 15:13,6:4,2 must not change behaviour
    setup(16'hE070, 16'd5);
    steps(3);
    chk("R2 ignored bits", cnt, 3);

    finish_run();
  end
endmodule